// File: doc/BRIEF.md
# Flash Program Status Poller

This block waits for a flash program or erase operation to finish. A separate command block writes the command sequence to the flash. It then pulses `start_i` with the target address, the command-set style and the operation type. It also supplies two time limits in clock ticks: a typical limit and a maximum limit.

The poller reads the status of the target address over a simple read master port, and repeats the read until the operation is complete or the time runs out. When it finishes it reports a one-cycle done pulse and an error code. It also keeps a saturating count, for each operation type, of how often each limit was passed.

Two command-set styles are supported:

- **Status-register style.** A ready bit signals completion. The remaining status bits are then decoded by priority into an error.
- **Toggle-bit style.** Each poll reads the same address twice. The operation is complete once bit 6 stops changing between the two reads.

Time is measured by a tick counter that restarts with each accepted start. The poller takes a time sample when it issues the first read of every poll. Because the sample comes before the check, one further check is always made after a limit has passed.

Top module: `flash_status_poller`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `busy_o`, `done_o` and `rd_req_o` are 0, `err_o` is 0 and every limit counter is 0.
- R2: `start_i` is taken only when `busy_o` is 0. At that point mode, operation type, address and both limits are captured. A `start_i` during a wait is ignored, and changes of these inputs during a wait have no effect.
- R3: Every read of a wait is presented on `rd_addr_o` with the captured address. `rd_req_o` stays high until `rd_ack_i`, and `rd_data_i` is taken in the acknowledge cycle.
- R4: Status mode (`mode_i`=0) uses one read per poll. The poll is complete when bit 7 of the word is 1. The poller ignores the other bits of any word whose bit 7 is 0. On completion, bits 7 and 0 and all bits above bit 7 are dropped before decoding.
- R5: On a completed status poll, `err_o` is chosen by priority from the kept bits:
  - bit 1 gives 1 (protected);
  - otherwise bit 4 gives 2 (program failure);
  - otherwise bit 5 gives 3 (erase failure);
  - otherwise any of bits 2, 3 or 6 gives 4 (other);
  - otherwise the code is 0.
- R6: Toggle mode (`mode_i`=1) makes two back-to-back reads per poll. The poll is complete, with `err_o`=0, when bit 6 is equal in both reads.
- R7: A poll's time sample is the number of clock edges from the start edge to the edge that raises `rd_req_o` for that poll's first read. The first poll of a wait therefore samples 0.
- R8: In a wait, the first poll whose sample is greater than the typical limit increments the typical counter of that operation type (0 erase, 1 write, 2 buffered write). This happens once per wait.
- R9: Every poll whose sample is greater than the maximum limit, once the typical limit has been passed in that wait, increments the maximum counter of that operation type. This applies even when that poll completes.
- R10: A poll that is not complete and whose sample is greater than the maximum limit ends the wait with `err_o`=5. No further read is issued.
- R11: Each counter saturates at all ones and belongs to one operation type only. Lane k sits at bits [k*CW +: CW].
- R12: `done_o` is a one-cycle pulse that ends each wait. `err_o` changes with that pulse and holds its value until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a wait (taken only when idle) |
| mode_i | input | 1 | 0 status-register style, 1 toggle-bit style |
| op_i | input | OPW | Operation type: 0 erase, 1 write, 2 buffered write |
| addr_i | input | AW | Address to poll |
| typ_lim_i | input | TW | Typical limit in ticks |
| max_lim_i | input | TW | Maximum limit in ticks |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | AW | Read address |
| rd_ack_i | input | 1 | Read acknowledge, data valid |
| rd_data_i | input | DW | Read data |
| busy_o | output | 1 | A wait is in progress |
| done_o | output | 1 | One-cycle end-of-wait pulse |
| err_o | output | 3 | Result code: 0 ok, 1 protected, 2 program, 3 erase, 4 other, 5 timeout |
| typ_cnt_o | output | NOPS*CW | Typical-limit overrun counters, one lane per type |
| max_cnt_o | output | NOPS*CW | Maximum-limit overrun counters, one lane per type |

## Verification
The bench targets the following corner cases:

- **Status words with several error bits set at once.** A design that decodes the priority in the wrong order reports erase where protect is due.
- **Junk in bit 0 and the upper byte.** A design that fails to mask these reports a generic error on a clean finish.
- **Not-ready words that carry error bits.** A poller that looks at these words ends a wait early.
- **Long waits that pass the typical limit on many polls.** A design that bumps the typical counter more than once per wait, or on the wrong lane, shows up here.
- **A poll that completes after the maximum limit has passed.** This must count a maximum overrun yet still report the status code rather than a timeout.
- **Saturation after hundreds of overruns.** This catches counters that wrap.
- **A second start in mid-wait.** This would corrupt the captured operation.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

  // Status-register bit positions
  localparam int unsigned FP_READY_BIT   = 7;
  localparam int unsigned FP_TOGGLE_BIT  = 6;
  localparam int unsigned FP_ERASE_BIT   = 5;
  localparam int unsigned FP_PROG_BIT    = 4;
  localparam int unsigned FP_PROTECT_BIT = 1;

  // Bits of the low byte that survive masking on completion
  localparam logic [7:0] FP_KEEP_BYTE = 8'b0111_1110;

  typedef enum logic [2:0] {
    FP_OK      = 3'd0,
    FP_PROTECT = 3'd1,
    FP_PROGRAM = 3'd2,
    FP_ERASE   = 3'd3,
    FP_OTHER   = 3'd4,
    FP_TIMEOUT = 3'd5
  } fp_err_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD1  = 2'd1,
    ST_RD2  = 2'd2,
    ST_EVAL = 2'd3
  } fp_state_e;

  localparam logic FP_MODE_STATUS = 1'b0;
  localparam logic FP_MODE_TOGGLE = 1'b1;

endpackage

// File: rtl/fpp_elapsed.sv
// Saturating tick counter restarted by each accepted start.
module fpp_elapsed #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  output logic [TW-1:0] tick_next
);
  localparam logic [TW-1:0] TOP = {TW{1'b1}};

  logic [TW-1:0] tick_q;

  always_comb begin
    if (restart)          tick_next = '0;
    else if (tick_q == TOP) tick_next = tick_q;
    else                  tick_next = tick_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) tick_q <= '0;
    else     tick_q <= tick_next;
  end
endmodule

// File: rtl/fpp_status_decode.sv
// Completion test and priority error decode for both command-set styles.
module fpp_status_decode
  import flash_poll_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          mode,
  input  logic [DW-1:0] first_w,
  input  logic          second_tog,
  output logic          complete,
  output fp_err_e       code
);
  localparam logic [DW-1:0] KEEP = DW'(FP_KEEP_BYTE);

  logic [DW-1:0] kept;

  assign kept = first_w & KEEP;

  always_comb begin
    code = FP_OK;
    if (mode == FP_MODE_TOGGLE) begin
      complete = (first_w[FP_TOGGLE_BIT] == second_tog);
    end else begin
      complete = first_w[FP_READY_BIT];
      if (complete) begin
        if (kept[FP_PROTECT_BIT])   code = FP_PROTECT;
        else if (kept[FP_PROG_BIT]) code = FP_PROGRAM;
        else if (kept[FP_ERASE_BIT]) code = FP_ERASE;
        else if (|kept)             code = FP_OTHER;
      end
    end
  end
endmodule

// File: rtl/fpp_limit_counters.sv
// One pair of saturating overrun counters per operation type.
module fpp_limit_counters #(
  parameter int NOPS = 3,
  parameter int OPW  = 2,
  parameter int CW   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OPW-1:0]    op,
  input  logic              typ_inc,
  input  logic              max_inc,
  output logic [NOPS*CW-1:0] typ_cnt,
  output logic [NOPS*CW-1:0] max_cnt
);
  localparam logic [CW-1:0] SAT = {CW{1'b1}};

  for (genvar g = 0; g < NOPS; g++) begin : g_lane
    logic          sel;
    logic [CW-1:0] t_q, m_q;

    assign sel = (op == OPW'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        t_q <= '0;
        m_q <= '0;
      end else begin
        if (sel && typ_inc && t_q != SAT) t_q <= t_q + 1'b1;
        if (sel && max_inc && m_q != SAT) m_q <= m_q + 1'b1;
      end
    end

    assign typ_cnt[g*CW +: CW] = t_q;
    assign max_cnt[g*CW +: CW] = m_q;
  end
endmodule

// File: rtl/flash_status_poller.sv
module flash_status_poller
  import flash_poll_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 16,   // at least 8
  parameter int TW   = 16,
  parameter int CW   = 8,
  parameter int NOPS = 3,
  parameter int OPW  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               mode_i,
  input  logic [OPW-1:0]     op_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [TW-1:0]      typ_lim_i,
  input  logic [TW-1:0]      max_lim_i,
  output logic               rd_req_o,
  output logic [AW-1:0]      rd_addr_o,
  input  logic               rd_ack_i,
  input  logic [DW-1:0]      rd_data_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [2:0]         err_o,
  output logic [NOPS*CW-1:0] typ_cnt_o,
  output logic [NOPS*CW-1:0] max_cnt_o
);
  fp_state_e      state_q;
  logic           mode_q;
  logic [OPW-1:0] op_q;
  logic [AW-1:0]  addr_q;
  logic [TW-1:0]  typ_lim_q, max_lim_q;
  logic [TW-1:0]  now_q;
  logic           typ_seen_q;
  logic [DW-1:0]  first_q;
  logic           second_tog_q;

  logic           accept;
  logic [TW-1:0]  tick_next;
  logic           complete;
  fp_err_e        code;
  logic           in_eval;
  logic           over_typ, over_max, past_typ;
  logic           typ_inc, max_inc;

  assign accept = (state_q == ST_IDLE) && start_i;

  fpp_elapsed #(.TW(TW)) u_elapsed (
    .clk       (clk),
    .rst       (rst),
    .restart   (accept),
    .tick_next (tick_next)
  );

  fpp_status_decode #(.DW(DW)) u_decode (
    .mode       (mode_q),
    .first_w    (first_q),
    .second_tog (second_tog_q),
    .complete   (complete),
    .code       (code)
  );

  assign in_eval  = (state_q == ST_EVAL);
  assign over_typ = (now_q > typ_lim_q);
  assign over_max = (now_q > max_lim_q);
  assign past_typ = typ_seen_q || over_typ;
  assign typ_inc  = in_eval && !typ_seen_q && over_typ;
  assign max_inc  = in_eval && past_typ && over_max;

  fpp_limit_counters #(.NOPS(NOPS), .OPW(OPW), .CW(CW)) u_counters (
    .clk     (clk),
    .rst     (rst),
    .op      (op_q),
    .typ_inc (typ_inc),
    .max_inc (max_inc),
    .typ_cnt (typ_cnt_o),
    .max_cnt (max_cnt_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      mode_q       <= FP_MODE_STATUS;
      op_q         <= '0;
      addr_q       <= '0;
      typ_lim_q    <= '0;
      max_lim_q    <= '0;
      now_q        <= '0;
      typ_seen_q   <= 1'b0;
      first_q      <= '0;
      second_tog_q <= 1'b0;
      rd_req_o     <= 1'b0;
      busy_o       <= 1'b0;
      done_o       <= 1'b0;
      err_o        <= FP_OK;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            mode_q     <= mode_i;
            op_q       <= op_i;
            addr_q     <= addr_i;
            typ_lim_q  <= typ_lim_i;
            max_lim_q  <= max_lim_i;
            now_q      <= tick_next;
            typ_seen_q <= 1'b0;
            err_o      <= FP_OK;
            rd_req_o   <= 1'b1;
            busy_o     <= 1'b1;
            state_q    <= ST_RD1;
          end
        end
        ST_RD1: begin
          if (rd_ack_i) begin
            first_q <= rd_data_i;
            if (mode_q == FP_MODE_TOGGLE) begin
              state_q <= ST_RD2;
            end else begin
              rd_req_o <= 1'b0;
              state_q  <= ST_EVAL;
            end
          end
        end
        ST_RD2: begin
          if (rd_ack_i) begin
            second_tog_q <= rd_data_i[FP_TOGGLE_BIT];
            rd_req_o     <= 1'b0;
            state_q      <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (typ_inc) typ_seen_q <= 1'b1;
          if (complete) begin
            err_o   <= code;
            done_o  <= 1'b1;
            busy_o  <= 1'b0;
            state_q <= ST_IDLE;
          end else if (over_max) begin
            err_o   <= FP_TIMEOUT;
            done_o  <= 1'b1;
            busy_o  <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            now_q    <= tick_next;
            rd_req_o <= 1'b1;
            state_q  <= ST_RD1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_addr_o = addr_q;

endmodule

// File: rtl/flash_status_poller_chk.sv
module flash_status_poller_chk #(
  parameter int AW   = 16,
  parameter int CW   = 8,
  parameter int NOPS = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               rd_req_o,
  input logic [AW-1:0]      rd_addr_o,
  input logic               busy_o,
  input logic               done_o,
  input logic [2:0]         err_o,
  input logic [NOPS*CW-1:0] typ_cnt_o,
  input logic [NOPS*CW-1:0] max_cnt_o
);
  AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o && $past(rd_req_o)) |-> $stable(rd_addr_o)); // R3

  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !rd_req_o); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R12

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o); // R12

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!done_o && !$rose(busy_o)) |-> $stable(err_o)); // R12

  AST_ERR_RANGE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (err_o <= 3'd5)); // R5

  for (genvar g = 0; g < NOPS; g++) begin : g_mono
    AST_TYP_STEP: assert property (@(posedge clk) disable iff (rst)
      (typ_cnt_o[g*CW +: CW] == $past(typ_cnt_o[g*CW +: CW])) ||
      (typ_cnt_o[g*CW +: CW] == $past(typ_cnt_o[g*CW +: CW]) + 1'b1)); // R11
    AST_MAX_STEP: assert property (@(posedge clk) disable iff (rst)
      (max_cnt_o[g*CW +: CW] == $past(max_cnt_o[g*CW +: CW])) ||
      (max_cnt_o[g*CW +: CW] == $past(max_cnt_o[g*CW +: CW]) + 1'b1)); // R11
  end
endmodule

bind flash_status_poller flash_status_poller_chk #(.AW(AW), .CW(CW), .NOPS(NOPS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_req_o  (rd_req_o),
  .rd_addr_o (rd_addr_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .err_o     (err_o),
  .typ_cnt_o (typ_cnt_o),
  .max_cnt_o (max_cnt_o)
);

// File: tb/flash_status_poller_bench.sv
`timescale 1ns/1ps
module flash_status_poller_bench;
  localparam int AW = 16, DW = 16, TW = 16, CW = 8, NOPS = 3, OPW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, mode_i = 1'b0;
  logic [OPW-1:0] op_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic [TW-1:0] typ_lim_i = '0, max_lim_i = '0;
  logic rd_req_o, rd_ack = 1'b0;
  logic [AW-1:0] rd_addr_o;
  logic [DW-1:0] rd_data = '0;
  logic busy_o, done_o;
  logic [2:0] err_o;
  logic [NOPS*CW-1:0] typ_cnt_o, max_cnt_o;

  always #5 clk = ~clk;

  flash_status_poller #(.AW(AW), .DW(DW), .TW(TW), .CW(CW), .NOPS(NOPS), .OPW(OPW)) u_flash_status_poller (
    .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i), .op_i(op_i), .addr_i(addr_i),
    .typ_lim_i(typ_lim_i), .max_lim_i(max_lim_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_ack_i(rd_ack), .rd_data_i(rd_data), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .typ_cnt_o(typ_cnt_o), .max_cnt_o(max_cnt_o));

  int n_chk = 0, n_fail = 0;
  int cyc = 0, start_cyc = 0;
  bit finished = 0;

  // flash model state
  bit m_active = 0, m_mode = 0, m_tog = 0, m_typ_seen = 0, m_end = 0;
  bit m_extra = 0, m_addr_bad = 0, first_tog = 0, prev_req = 0;
  int m_op = 0, m_remain = 0, m_lat = 0, wait_cnt = -1, reads_in = 0, s_cur = 0;
  int m_typ = 0, m_max = 0;
  logic [DW-1:0] m_final = '0;
  logic [AW-1:0] cur_addr = '0;
  logic [2:0] exp_err = 3'd0;
  logic [CW-1:0] exp_typ [NOPS];
  logic [CW-1:0] exp_max [NOPS];

  initial forever begin @(posedge clk); cyc++; end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] dec(input logic [DW-1:0] w);
    if (w[1]) return 3'd1;
    if (w[4]) return 3'd2;
    if (w[5]) return 3'd3;
    if (w[6] | w[3] | w[2]) return 3'd4;
    return 3'd0;
  endfunction

  function automatic logic [NOPS*CW-1:0] pack(input bit which_max);
    logic [NOPS*CW-1:0] v;
    for (int i = 0; i < NOPS; i++) v[i*CW +: CW] = which_max ? exp_max[i] : exp_typ[i];
    return v;
  endfunction

  task automatic poll_end(input bit complete, input logic [DW-1:0] w);
    if (m_end) return;
    if (!m_typ_seen && s_cur > m_typ) begin
      m_typ_seen = 1;
      if (exp_typ[m_op] != {CW{1'b1}}) exp_typ[m_op]++;
    end
    if (m_typ_seen && s_cur > m_max)
      if (exp_max[m_op] != {CW{1'b1}}) exp_max[m_op]++;
    if (complete) begin
      exp_err = m_mode ? 3'd0 : dec(w);
      m_end = 1;
    end else if (s_cur > m_max) begin
      exp_err = 3'd5;
      m_end = 1;
    end
  endtask

  task automatic serve_read();
    logic [DW-1:0] w;
    if (rd_addr_o != cur_addr) m_addr_bad = 1;
    w = DW'($urandom);
    if (!m_mode) begin
      if (m_remain > 0) begin m_remain--; w[7] = 1'b0; end
      else w = m_final;
      rd_data = w;
      poll_end(w[7], w);
    end else begin
      if (m_remain > 0) begin m_tog = ~m_tog; m_remain--; end
      w[6] = m_tog;
      rd_data = w;
      if (reads_in == 0) begin first_tog = m_tog; reads_in = 1; end
      else poll_end(first_tog == m_tog, w);
    end
  endtask

  // read responder
  initial forever begin
    @(negedge clk);
    if (rst) begin
      rd_ack = 0; wait_cnt = -1; prev_req = 0;
    end else begin
      if (rd_req_o && !prev_req && m_active) begin
        if (m_end) m_extra = 1;
        s_cur = cyc - start_cyc;
        reads_in = 0;
      end
      prev_req = rd_req_o;
      if (rd_ack) rd_ack = 0;
      else if (rd_req_o) begin
        if (wait_cnt < 0) wait_cnt = int'($urandom % (m_lat + 1));
        if (wait_cnt == 0) begin wait_cnt = -1; serve_read(); rd_ack = 1; end
        else wait_cnt--;
      end
    end
  end

  task automatic run_op(input bit md, input int opc, input int rem, input logic [DW-1:0] fin,
                        input int tl, input int ml, input int lat, input bit poke, input string tag);
    bit got;
    @(negedge clk);
    m_mode = md; m_op = opc; m_remain = rem; m_final = fin | DW'(16'h0080);
    m_tog = 1'($urandom); m_lat = lat; m_typ = tl; m_max = ml;
    m_typ_seen = 0; m_end = 0; m_extra = 0; m_addr_bad = 0; exp_err = 3'd0;
    cur_addr = AW'($urandom);
    start_i = 1; mode_i = md; op_i = OPW'(opc); addr_i = cur_addr;
    typ_lim_i = TW'(tl); max_lim_i = TW'(ml);
    start_cyc = cyc + 1; m_active = 1;
    @(negedge clk);
    start_i = 0; addr_i = AW'($urandom); mode_i = ~md; op_i = OPW'((opc + 1) % 3);
    typ_lim_i = TW'($urandom); max_lim_i = TW'($urandom);
    if (poke) begin
      @(negedge clk);
      start_i = 1;  // R2: ignored while busy
      @(negedge clk);
      start_i = 0;
    end
    got = 0;
    for (int k = 0; k < 4000 && !got; k++) begin
      @(negedge clk);
      if (done_o) got = 1;
    end
    chk(got, "R12", "done seen", got, 1);
    chk(err_o == exp_err, tag, "err code", err_o, exp_err);
    chk(typ_cnt_o == pack(0), "R8", "typ counters", typ_cnt_o, pack(0));
    chk(max_cnt_o == pack(1), "R9", "max counters", max_cnt_o, pack(1));
    chk(!m_extra, "R10", "no poll after end", m_extra, 0);
    chk(!m_addr_bad, "R3", "read address", m_addr_bad, 0);
    @(negedge clk);
    chk(!done_o && err_o == exp_err && !busy_o, "R12", "pulse end / err hold",
        {done_o, err_o}, {1'b0, exp_err});
    m_active = 0;
  endtask

  initial begin
    void'($urandom(32'h5EED_F1A5));
    for (int i = 0; i < NOPS; i++) begin exp_typ[i] = '0; exp_max[i] = '0; end
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !rd_req_o && err_o == 0 && typ_cnt_o == 0 && max_cnt_o == 0,
        "R1", "reset state", {busy_o, done_o, rd_req_o, err_o}, 0);
    rst = 0;
    @(negedge clk);
    chk(!busy_o && !rd_req_o && typ_cnt_o == 0 && max_cnt_o == 0, "R1", "after reset",
        {busy_o, rd_req_o}, 0);

    // R5 priority cases, status mode
    run_op(0, 0, 2, 16'h00B2, 100, 200, 1, 0, "R5");  // protect wins
    run_op(0, 1, 1, 16'h00B0, 100, 200, 0, 0, "R5");  // program over erase
    run_op(0, 2, 0, 16'h00A8, 100, 200, 2, 0, "R5");  // erase over other
    run_op(0, 0, 0, 16'h0084, 100, 200, 0, 0, "R5");  // other
    run_op(0, 1, 3, 16'hFF01, 100, 200, 3, 0, "R4");  // masked bits only -> ok
    // R6 toggle mode
    run_op(1, 2, 0, 16'h0000, 100, 200, 1, 0, "R6");
    run_op(1, 0, 5, 16'h0000, 100, 300, 2, 0, "R6");
    // R8 typical counted once over many late polls; R7 samples
    run_op(0, 1, 6, 16'h0080, 2, 1000, 1, 0, "R8");
    // R10 timeout
    run_op(0, 2, 1000, 16'h0080, 1, 5, 1, 0, "R10");
    run_op(1, 1, 1000, 16'h0080, 0, 9, 0, 0, "R10");
    // R9 completion past maximum still reports status
    run_op(0, 0, 1, 16'h00A0, 0, 0, 0, 0, "R9");
    // R2 start ignored while busy
    run_op(0, 2, 4, 16'h0090, 3, 500, 2, 1, "R2");
    run_op(1, 0, 4, 16'h0000, 3, 500, 1, 1, "R2");

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [DW-1:0] fin;
      fin = ($urandom % 4 == 0) ? DW'($urandom) : (DW'($urandom) & DW'(16'hFF01));
      run_op(1'($urandom), int'($urandom % 3), int'($urandom % 7), fin,
             int'($urandom % 40), int'($urandom % 60), int'($urandom % 4),
             0, "R5");
    end

    // R11 saturation on the write lane
    for (int n = 0; n < 260; n++) run_op(0, 1, 1, 16'h0080, 0, 0, 0, 0, "R11");
    chk(typ_cnt_o[CW +: CW] == {CW{1'b1}}, "R11", "typ lane saturated", typ_cnt_o[CW +: CW], {CW{1'b1}});
    chk(max_cnt_o[CW +: CW] == {CW{1'b1}}, "R11", "max lane saturated", max_cnt_o[CW +: CW], {CW{1'b1}});

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    wait (cyc >= 180000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule